// File: doc/BRIEF.md
# Disk Command Decoder and Seek Sequencer

This block sits behind the command channel of a two-drive disk controller. When the channel pulses set-control while the command flip-flop is clear, it latches a command word, decodes a function code and a drive number, and runs the functions that move no sector data. These are seek, recalibrate, load address and status check. Read, write, read address, write address, address skip and check are handed to a separate transfer engine through a start strobe.

The controller owns one record address register with cylinder, head and sector fields, shared by both drives. It is filled from two consecutive data-channel words. Each drive has its own cylinder/head position register, its own status byte and its own seek timer. A seek takes a number of cycles equal to the cylinder distance times a per-cylinder time. Seek completion is reported on the command-done strobe only when the transfer engine is idle and the command flag is down.

Top module: `disk_seq_ctrl`

## Requirements
- R1: The function code is `cmd_word[15:12]` and the drive is `cmd_word[0]`. The codes are 1 status, 2 recalibrate, 3 seek, 4 read, 5 write, 6 read address, 7 write address, 8 check, 11 load address and 12 address skip. A `cmd_set` pulse while `cmd_busy` is high is ignored. Any other code sets `cmd_busy` and does nothing else.
- R2: After reset, `cmd_busy` is low, all strobes are low, and the address register, both positions and both status bytes are zero.
- R3: Load address takes two data words. The first gives the cylinder in bits 7:0. The second gives the head in bits 12:8 and the sector in bits 4:0. `dat_ack` pulses once for each word. `cmd_done` pulses together with the second acknowledge, and `cmd_busy` drops at the same time. Drive positions do not change.
- R4: Seek takes the same two words. It then copies cylinder and head into the drive's position and starts that drive's timer for |new−old|·CYL_TIME cycles. `cmd_done` follows one cycle after the timer expires. While the timer runs, status bit 2 (busy) is set, and it is cleared when the timer expires.
- R5: A seek to the cylinder the drive is already on takes MIN_TIME cycles and does not set the busy bit.
- R6: If a seek ends at a cylinder of MAX_CYL (203) or more, status bits 2 and 0 are set and the drive position is forced to cylinder 0.
- R7: A finished seek raises `cmd_done` only in a cycle where both `cmd_flag` and `xfer_busy` are low. Until then it waits.
- R8: Recalibrate zeroes the address register at once. If the drive's timer is idle, it also zeroes the drive position and times a move of cur_cyl·CYL_TIME cycles (MIN_TIME when already at 0). If the timer is running, the position is left alone.
- R9: A status check waits for one data word, then returns the status on `dat_in` with `dat_ack` and drops `cmd_busy`. The bits are: 7 drive is 1, 6 not ready, 5 end of cylinder, 4 address error, 3 flagged, 2 busy, 1 data error, 0 any error. Bit 0 is also forced when any of bits 6,5,4,3,1 is set.
- R10: For a drive whose `drv_loaded` bit is low, the status word holds only bit 6, bit 0 and the drive bit.
- R11: A status read clears the stored bits 6,5,4,3,1 of that drive and keeps bits 2 and 0.
- R12: Seek, recalibrate, check and the transfer functions clear the drive's status byte when they start.
- R13: The transfer codes 4,5,6,7,12 pulse `xfer_start` with `xfer_fn` and `xfer_drv` at once. Check first waits for one data word, then pulses `xfer_start` with `xfer_fn`=8 and `xfer_cnt` set to word bits 8:0. No `dat_ack` is given for that word.
- R14: `cmd_clr` drops `cmd_busy` and abandons any wait for data words. A running seek timer keeps running and still reports completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | 16 | Command word from the command channel buffer |
| cmd_set | input | 1 | Set-control pulse on the command channel |
| cmd_clr | input | 1 | Clear-control pulse / end of transfer |
| cmd_flag | input | 1 | Command channel flag state |
| xfer_busy | input | 1 | Transfer engine busy |
| dat_valid | input | 1 | A data-channel word is offered |
| dat_word | input | 16 | Offered data-channel word |
| dat_ack | output | 1 | Word accepted; data flag set |
| dat_in | output | 16 | Status word returned to the data channel |
| cmd_done | output | 1 | Set the command channel flag |
| cmd_busy | output | 1 | Command flip-flop |
| drv_loaded | input | 2 | Heads loaded, one bit per drive |
| err_set | input | 1 | Transfer engine reports status bits |
| err_drv | input | 1 | Drive for `err_set` |
| err_bits | input | 8 | Status bits to OR in (bit 7 ignored) |
| xfer_start | output | 1 | Start a data-moving function |
| xfer_fn | output | 4 | Function for the transfer engine |
| xfer_drv | output | 1 | Drive for the transfer engine |
| xfer_cnt | output | 9 | Sector count for check |
| rar_cyl | output | 8 | Address register cylinder |
| rar_head | output | 5 | Address register head |
| rar_sec | output | 5 | Address register sector |
| pos_cyl | output | 16 | Drive cylinders, drive 1 in bits 15:8 |
| pos_head | output | 10 | Drive heads, drive 1 in bits 9:5 |

## Verification
A corrupted drive position shows up on `pos_cyl` at once, and again one seek later as a wrong completion delay. A wrong timer load or a missed expiry moves the `cmd_done` pulse away from the cycle count expected for the cylinder distance. A lost or stale status bit can only be seen on the next status check, so the tests read status right after each seek, after each error report and twice in a row. A sequencer stuck in a word-wait shows up as a missing acknowledge or a `cmd_busy` that stays high.

// File: rtl/disk_seq_ctrl.sv
module disk_seq_ctrl #(
  parameter int CYL_TIME = 4,
  parameter int MIN_TIME = 3,
  parameter int MAX_CYL  = 203
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cmd_word,
  input  logic        cmd_set,
  input  logic        cmd_clr,
  input  logic        cmd_flag,
  input  logic        xfer_busy,
  input  logic        dat_valid,
  input  logic [15:0] dat_word,
  output logic        dat_ack,
  output logic [15:0] dat_in,
  output logic        cmd_done,
  output logic        cmd_busy,
  input  logic [1:0]  drv_loaded,
  input  logic        err_set,
  input  logic        err_drv,
  input  logic [7:0]  err_bits,
  output logic        xfer_start,
  output logic [3:0]  xfer_fn,
  output logic        xfer_drv,
  output logic [8:0]  xfer_cnt,
  output logic [7:0]  rar_cyl,
  output logic [4:0]  rar_head,
  output logic [4:0]  rar_sec,
  output logic [15:0] pos_cyl,
  output logic [9:0]  pos_head
);
  localparam int NDRV = 2;
  localparam int TW = $clog2(256 * CYL_TIME + MIN_TIME + 1);
  localparam logic [7:0] CYL_LIM = 8'(MAX_CYL);
  localparam logic [7:0] STICKY = 8'h7A;

  typedef enum logic [2:0] {IDLE, GET_CYL, GET_HS, GET_STA, GET_CNT} st_t;

  st_t         st;
  logic        la_q, drv_q;
  logic [7:0]  cyl [NDRV];
  logic [4:0]  hd  [NDRV];
  logic [7:0]  sta [NDRV];
  logic [TW-1:0] tmr [NDRV];
  logic [NDRV-1:0] pend, act, grant;

  wire [3:0] fn   = cmd_word[15:12];
  wire       cd   = cmd_word[0];
  wire       take = cmd_set & ~cmd_ff_n();
  wire       free = ~xfer_busy & ~cmd_flag;
  wire       unused_bits = ^{cmd_word[11:1], dat_word[15:13]};

  function automatic logic cmd_ff_n();
    return cmd_busy | cmd_clr;
  endfunction

  always_comb
    for (int d = 0; d < NDRV; d++) act[d] = (tmr[d] != '0) | pend[d];

  assign grant[0] = pend[0] & free;
  assign grant[1] = pend[1] & free & ~pend[0];

  wire [7:0] sk_diff = (rar_cyl >= cyl[drv_q]) ? rar_cyl - cyl[drv_q] : cyl[drv_q] - rar_cyl;
  wire [TW-1:0] sk_time = (sk_diff == 8'd0) ? TW'(MIN_TIME) : TW'(sk_diff) * TW'(CYL_TIME);
  wire [TW-1:0] rc_time = (cyl[cd] == 8'd0) ? TW'(MIN_TIME) : TW'(cyl[cd]) * TW'(CYL_TIME);

  wire [7:0]  sbase = drv_loaded[drv_q] ? {1'b0, sta[drv_q][6:0]} : 8'h40;
  wire [15:0] sword = {8'h00, drv_q, sbase[6:1], sbase[0] | (|(sbase & STICKY))};

  assign pos_cyl  = {cyl[1], cyl[0]};
  assign pos_head = {hd[1], hd[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; la_q <= 1'b0; drv_q <= 1'b0; cmd_busy <= 1'b0;
      dat_ack <= 1'b0; dat_in <= '0; cmd_done <= 1'b0;
      xfer_start <= 1'b0; xfer_fn <= '0; xfer_drv <= 1'b0; xfer_cnt <= '0;
      rar_cyl <= '0; rar_head <= '0; rar_sec <= '0; pend <= '0;
      for (int d = 0; d < NDRV; d++) begin
        cyl[d] <= '0; hd[d] <= '0; sta[d] <= '0; tmr[d] <= '0;
      end
    end else begin
      dat_ack <= 1'b0;
      cmd_done <= 1'b0;
      xfer_start <= 1'b0;
      for (int d = 0; d < NDRV; d++) begin
        if (tmr[d] != '0) begin
          tmr[d] <= tmr[d] - 1'b1;
          if (tmr[d] == TW'(1)) begin
            pend[d] <= 1'b1;
            if (cyl[d] >= CYL_LIM) begin
              sta[d] <= sta[d] | 8'h05;
              cyl[d] <= '0;
            end else
              sta[d][2] <= 1'b0;
          end
        end
        if (grant[d]) begin
          pend[d] <= 1'b0;
          cmd_done <= 1'b1;
          cmd_busy <= 1'b0;
        end
      end

      if (cmd_clr) begin
        cmd_busy <= 1'b0;
        st <= IDLE;
      end else if (take) begin
        cmd_busy <= 1'b1;
        drv_q <= cd;
        case (fn)
          4'h1: st <= GET_STA;
          4'h2: begin
            rar_cyl <= '0; rar_head <= '0; rar_sec <= '0;
            sta[cd] <= '0;
            if (!act[cd]) begin
              tmr[cd] <= rc_time;
              if (cyl[cd] != 8'd0) sta[cd] <= 8'h04;
              cyl[cd] <= '0;
              hd[cd] <= '0;
            end
          end
          4'h3: begin sta[cd] <= '0; la_q <= 1'b0; st <= GET_CYL; end
          4'hB: begin la_q <= 1'b1; st <= GET_CYL; end
          4'h8: begin sta[cd] <= '0; st <= GET_CNT; end
          4'h4, 4'h5, 4'h6, 4'h7, 4'hC: begin
            sta[cd] <= '0;
            xfer_start <= 1'b1;
            xfer_fn <= fn;
            xfer_drv <= cd;
          end
          default: ;
        endcase
      end else if (dat_valid) begin
        case (st)
          GET_CYL: begin
            rar_cyl <= dat_word[7:0];
            dat_ack <= 1'b1;
            st <= GET_HS;
          end
          GET_HS: begin
            rar_head <= dat_word[12:8];
            rar_sec <= dat_word[4:0];
            dat_ack <= 1'b1;
            st <= IDLE;
            if (la_q) begin
              cmd_busy <= 1'b0;
              cmd_done <= 1'b1;
            end else if (!act[drv_q]) begin
              cyl[drv_q] <= rar_cyl;
              hd[drv_q] <= dat_word[12:8];
              tmr[drv_q] <= sk_time;
              if (sk_diff != 8'd0) sta[drv_q][2] <= 1'b1;
            end
          end
          GET_STA: begin
            dat_in <= sword;
            dat_ack <= 1'b1;
            cmd_busy <= 1'b0;
            sta[drv_q] <= sta[drv_q] & ~STICKY;
            st <= IDLE;
          end
          GET_CNT: begin
            xfer_cnt <= dat_word[8:0];
            xfer_start <= 1'b1;
            xfer_fn <= 4'h8;
            xfer_drv <= drv_q;
            st <= IDLE;
          end
          default: ;
        endcase
      end

      if (err_set) sta[err_drv] <= sta[err_drv] | (err_bits & 8'h7F);
    end
  end
endmodule

// File: rtl/disk_seq_ctrl_chk.sv
module disk_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cmd_word,
  input logic        cmd_set,
  input logic        cmd_clr,
  input logic        cmd_flag,
  input logic        xfer_busy,
  input logic        dat_valid,
  input logic        dat_ack,
  input logic [15:0] dat_in,
  input logic        cmd_done,
  input logic        cmd_busy,
  input logic        xfer_start,
  input logic [3:0]  xfer_fn,
  input logic [7:0]  rar_cyl,
  input logic [4:0]  rar_head,
  input logic [4:0]  rar_sec
);
  AST_DONE_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !$past(cmd_set) |-> !cmd_busy); // R4

  AST_DONE_WAITS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !dat_ack |-> !$past(cmd_flag) && !$past(xfer_busy)); // R7

  AST_ACK_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ack |-> $past(dat_valid) && !$past(cmd_clr)); // R3

  AST_ANYERR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dat_in & 16'h007A)) |-> dat_in[0]); // R9

  AST_XFER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (xfer_fn inside {4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'hC})); // R13

  AST_BUSY_IGNORES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_busy) && $past(cmd_set) && !$past(dat_valid) |-> !xfer_start); // R1

  AST_RECAL_ZEROES_RAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_set) && !$past(cmd_busy) && !$past(cmd_clr) && $past(cmd_word[15:12]) == 4'h2
    |-> rar_cyl == 8'd0 && rar_head == 5'd0 && rar_sec == 5'd0); // R8
endmodule

bind disk_seq_ctrl disk_seq_ctrl_chk u_chk (.*);

// File: tb/tb_disk_seq_ctrl.sv
`timescale 1ns/1ps
module tb_disk_seq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cmd_word = '0, dat_word = '0;
  logic cmd_set = 0, cmd_clr = 0, cmd_flag = 0, xfer_busy = 0, dat_valid = 0;
  logic [1:0] drv_loaded = 2'b11;
  logic err_set = 0, err_drv = 0;
  logic [7:0] err_bits = '0;
  logic dat_ack, cmd_done, cmd_busy, xfer_start, xfer_drv;
  logic [15:0] dat_in, pos_cyl;
  logic [3:0] xfer_fn;
  logic [8:0] xfer_cnt;
  logic [7:0] rar_cyl;
  logic [4:0] rar_head, rar_sec;
  logic [9:0] pos_head;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  disk_seq_ctrl dut (.*);

  // {drive, cylinder, head, sector, expected cycles to done}
  localparam logic [30:0] SEEKS [5] = '{
    {1'b0, 8'd10,  5'd3, 5'd5,  12'd41},
    {1'b0, 8'd10,  5'd7, 5'd1,  12'd4},
    {1'b1, 8'd200, 5'd2, 5'd22, 12'd801},
    {1'b0, 8'd2,   5'd0, 5'd0,  12'd33},
    {1'b1, 8'd200, 5'd1, 5'd9,  12'd4}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic [15:0] w);
    @(negedge clk); cmd_word = w; cmd_set = 1;
    @(negedge clk); cmd_set = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); cmd_clr = 1;
    @(negedge clk); cmd_clr = 0;
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk); dat_word = w; dat_valid = 1;
    @(negedge clk); dat_valid = 0;
  endtask

  task automatic report_err(input logic d, input logic [7:0] b);
    @(negedge clk); err_set = 1; err_drv = d; err_bits = b;
    @(negedge clk); err_set = 0;
  endtask

  task automatic read_status(input logic d, output logic [15:0] v);
    pulse_cmd({4'h1, 11'h0, d});
    send_word(16'h0000);
    chk("R9 status ack", dat_ack, 1);
    v = dat_in;
  endtask

  task automatic do_seek(input logic d, input logic [7:0] c, input logic [4:0] h, input logic [4:0] s);
    pulse_cmd({4'h3, 11'h0, d});
    send_word({8'h00, c});
    chk("R4 seek ack word1", dat_ack, 1);
    send_word({3'b000, h, 3'b000, s});
    chk("R4 seek ack word2", dat_ack, 1);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (cmd_done !== 1'b1 && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] sw;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset cmd_busy", cmd_busy, 0);
    chk("R2 reset strobes", {dat_ack, cmd_done, xfer_start}, 0);
    chk("R2 reset rar", {rar_cyl, rar_head, rar_sec}, 0);
    chk("R2 reset pos", {pos_cyl, pos_head}, 0);

    // R3 load address
    pulse_cmd(16'hB000);
    send_word(16'h0055);
    chk("R3 la ack1", dat_ack, 1);
    chk("R3 la no early done", cmd_done, 0);
    send_word({3'b000, 5'd9, 3'b000, 5'd17});
    chk("R3 la ack2", dat_ack, 1);
    chk("R3 la done", cmd_done, 1);
    chk("R3 la cmd_busy", cmd_busy, 0);
    chk("R3 la rar", {rar_cyl, rar_head, rar_sec}, {8'h55, 5'd9, 5'd17});
    chk("R3 la pos untouched", pos_cyl, 0);

    // R1 set-control ignored while command busy
    pulse_cmd(16'h1001);
    pulse_cmd(16'h3000);
    send_word(16'h0000);
    chk("R1 ignored set ack", dat_ack, 1);
    chk("R1 ignored set status", dat_in, 16'h0080);
    chk("R1 cmd_busy after status", cmd_busy, 0);

    // R4/R5 seek table
    for (int i = 0; i < 5; i++) begin
      logic [30:0] v;
      v = SEEKS[i];
      do_seek(v[30], v[29:22], v[21:17], v[16:12]);
      wait_done(n);
      chk("R4 R5 seek cycles", n, v[11:0]);
      chk("R4 pos cyl", v[30] ? pos_cyl[15:8] : pos_cyl[7:0], v[29:22]);
      chk("R4 pos head", v[30] ? pos_head[9:5] : pos_head[4:0], v[21:17]);
      chk("R3 R4 rar", {rar_cyl, rar_head, rar_sec}, v[29:12]);
      @(negedge clk);
      chk("R4 cmd_busy after done", cmd_busy, 0);
      read_status(v[30], sw);
      chk("R4 busy cleared", sw, v[30] ? 16'h0080 : 16'h0000);
    end

    // R7 completion deferred by command flag
    cmd_flag = 1;
    do_seek(0, 8'd3, 5'd0, 5'd0);
    n = 0;
    repeat (20) begin @(negedge clk); if (cmd_done) n++; end
    chk("R7 no done while flag", n, 0);
    cmd_flag = 0;
    @(negedge clk);
    chk("R7 done once flag clear", cmd_done, 1);

    // R7 completion deferred by transfer busy
    xfer_busy = 1;
    do_seek(0, 8'd4, 5'd0, 5'd0);
    n = 0;
    repeat (20) begin @(negedge clk); if (cmd_done) n++; end
    chk("R7 no done while xfer busy", n, 0);
    xfer_busy = 0;
    @(negedge clk);
    chk("R7 done once xfer idle", cmd_done, 1);

    // R4 busy bit visible; R14 clear keeps timer
    do_seek(0, 8'd13, 5'd0, 5'd0);
    pulse_clr();
    chk("R14 cmd_busy cleared", cmd_busy, 0);
    read_status(0, sw);
    chk("R4 busy while seeking", sw, 16'h0004);
    wait_done(n);
    chk("R14 seek still completes", cmd_done, 1);
    read_status(0, sw);
    chk("R4 busy cleared at end", sw, 16'h0000);

    // R6 seek past last cylinder
    do_seek(1, 8'd210, 5'd0, 5'd7);
    wait_done(n);
    chk("R6 seek cycles", n, 41);
    chk("R6 pos forced to 0", pos_cyl[15:8], 0);
    read_status(1, sw);
    chk("R6 busy and error", sw, 16'h0085);
    read_status(1, sw);
    chk("R11 bits 2,0 kept", sw, 16'h0085);

    // R9/R11 sticky error bits
    report_err(0, 8'h1A);
    read_status(0, sw);
    chk("R9 any-error summary", sw, 16'h001B);
    read_status(0, sw);
    chk("R11 sticky cleared", sw, 16'h0000);

    // R10 unloaded drive
    drv_loaded = 2'b01;
    read_status(1, sw);
    chk("R10 unloaded status", sw, 16'h00C1);
    drv_loaded = 2'b11;

    // R8/R12 recalibrate from cylinder 13
    report_err(0, 8'h10);
    pulse_cmd(16'h2000);
    chk("R8 rar zero", {rar_cyl, rar_head, rar_sec}, 0);
    wait_done(n);
    chk("R8 recal cycles", n, 53);
    chk("R8 pos zero", {pos_cyl[7:0], pos_head[4:0]}, 0);
    read_status(0, sw);
    chk("R12 recal cleared status", sw, 16'h0000);

    // R8 recalibrate ignored while drive timer runs
    do_seek(0, 8'd50, 5'd0, 5'd0);
    pulse_clr();
    pulse_cmd(16'h2000);
    chk("R8 rar zero while busy", rar_cyl, 0);
    chk("R8 pos kept while busy", pos_cyl[7:0], 8'd50);
    wait_done(n);
    chk("R8 seek done after ignored recal", cmd_done, 1);
    chk("R8 pos still kept", pos_cyl[7:0], 8'd50);

    // R13/R12 transfer start
    report_err(1, 8'h02);
    pulse_cmd(16'h4001);
    chk("R13 read start", {xfer_start, xfer_fn, xfer_drv}, {1'b1, 4'h4, 1'b1});
    chk("R13 cmd_busy held", cmd_busy, 1);
    pulse_clr();
    read_status(1, sw);
    chk("R12 transfer cleared status", sw, 16'h0080);

    // R13 check waits for count word
    pulse_cmd(16'h8000);
    chk("R13 check no immediate start", xfer_start, 0);
    send_word(16'h1234);
    chk("R13 check start", {xfer_start, xfer_fn}, {1'b1, 4'h8});
    chk("R13 check count", xfer_cnt, 9'h034);
    chk("R13 check no ack", dat_ack, 0);
    pulse_clr();

    // R1 unused code
    pulse_cmd(16'h9000);
    chk("R1 unused code busy", cmd_busy, 1);
    chk("R1 unused code no start", xfer_start, 0);
    send_word(16'h00AA);
    chk("R1 unused code no ack", dat_ack, 0);
    chk("R1 unused code rar", rar_cyl, 0);
    pulse_clr();

    // R14 abandon word wait
    pulse_cmd(16'hB000);
    send_word(16'h0011);
    pulse_clr();
    send_word(16'h0022);
    chk("R14 no ack after clear", dat_ack, 0);
    chk("R14 rar kept", rar_cyl, 8'h11);
    chk("R14 cmd_busy low", cmd_busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule